// File: doc/BRIEF.md
# ADC Serial Register Interface

This block is the serial control port of a precision converter front end. An external host, acting as SPI master (mode 3 style: data captured on the rising SCLK edge, changed after the falling edge), reaches eight register addresses through it: a status byte, an operating-mode word, a configuration word, the latest conversion result, an identification byte, and a per-channel pair of offset and gain calibration words. The converter core sits beside it and hands each finished result over through a one-cycle strobe carrying the value and the channel it belongs to.

All pins are oversampled by the block's system clock, so SCLK must stay well below that clock. Each transaction starts with a command byte. The command's address selects a register whose width (one, two or three bytes) fixes how many bytes follow. The single data pin carries read data during a read. At every other time while the chip select is asserted, it carries the inverted data-ready flag, so a host can wait for a low level on it before fetching the result.

Top module: `adc_spi_regs`

## Requirements
- R1: After reset the mode word reads 0x000A, the configuration word 0x0710, every offset word 0x800000, every gain word 0x555555, the status byte 0x88 and the result 0x000000.
- R2: A core strobe loads the result word and its channel number and clears the data-ready-low flag (status bit 7) on the next clock.
- R3: A read that shifts out all three bytes of the result register (address 3) sets status bit 7 again.
- R4: While chip select is high the data pin is not driven (`dout_en` low). While it is low and no read data is being shifted, `dout` equals status bit 7.
- R5: A command byte has bit 7 = 0 (a byte with bit 7 = 1 is dropped and the next byte is taken as a new command), bit 6 = 1 for read, and bits 5:3 = address. Bits are sent MSB first. The data phase lasts 1 byte for addresses 0, 4 and 5, 2 bytes for addresses 1 and 2, and 3 bytes for addresses 3, 6 and 7.
- R6: The identification byte (address 4) reads 0x0B: bits 3:1 = 101 and bit 0 = 1 for the 24-bit width, with the upper nibble a parameter (default 0).
- R7: The status byte (address 0) holds data-ready-low in bit 7, zeros in bits 6:4, 1 in bit 3, and in bits 2:0 the channel of the held result.
- R8: The mode (address 1) and configuration (address 2) words can be written at any time. Writes to addresses 0, 3, 4 and 5 change nothing.
- R9: Four offset/gain banks exist. Configuration bits 1:0 choose the bank reached at addresses 6 (offset) and 7 (gain) and shown on `cal_offset` and `cal_gain`.
- R10: An offset or gain write takes effect only when mode bits 15:13 are 010 (idle) or 011 (sleep). Reads are always allowed.
- R11: Thirty-two consecutive 1s sampled on DIN return the interface to waiting for a command without touching any register.
- R12: Raising chip select in the middle of a transaction abandons it. A write that is not complete is not committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Chip select, active low |
| din | input | 1 | Serial data from the host |
| dout | output | 1 | Serial read data or inverted data-ready flag |
| dout_en | output | 1 | Output enable for the shared data pin |
| smp_valid | input | 1 | One-cycle strobe: a new conversion result is ready |
| smp_word | input | 24 | Conversion result accompanying the strobe |
| smp_chan | input | 3 | Channel number of that result |
| mode_q | output | 16 | Current mode word |
| cfg_q | output | 16 | Current configuration word |
| cal_offset | output | 24 | Offset word of the selected bank |
| cal_gain | output | 24 | Gain word of the selected bank |

## Verification
The hardest state to reach from the pins is a framing slip with chip select held low. The stimulus sends three stray bits so that the following 1s form a write command to the read-only result register, whose 24-bit data phase then absorbs most of the run. The thirty-second 1 therefore lands two bits into a new command byte, and a correct recovery is shown when the very next read of the mode word returns the right value. Bank write protection is covered by toggling the mode between converting, idle and sleep around offset and gain writes on two banks, and by checking the other bank for leaks.

// File: rtl/adcspi_pkg.sv
package adcspi_pkg;

    localparam int WORD_W = 24;

    typedef enum logic [2:0] {
        A_STAT = 3'd0,
        A_MODE = 3'd1,
        A_CONF = 3'd2,
        A_DATA = 3'd3,
        A_IDEN = 3'd4,
        A_RSVD = 3'd5,
        A_OFFS = 3'd6,
        A_GAIN = 3'd7
    } reg_addr_e;

    typedef enum logic {PH_CMD, PH_DATA} phase_e;

    typedef struct packed {
        logic      rd;
        reg_addr_e addr;
    } cmd_t;

    localparam logic [15:0]       MODE_RST = 16'h000A;
    localparam logic [15:0]       CONF_RST = 16'h0710;
    localparam logic [WORD_W-1:0] OFFS_RST = 24'h800000;
    localparam logic [WORD_W-1:0] GAIN_RST = 24'h555555;

    function automatic logic [1:0] reg_bytes(reg_addr_e a);
        case (a)
            A_MODE, A_CONF:         return 2'd2;
            A_DATA, A_OFFS, A_GAIN: return 2'd3;
            default:                return 2'd1;
        endcase
    endfunction

    function automatic logic cal_writable(logic [2:0] md);
        return (md == 3'b010) || (md == 3'b011);
    endfunction

endpackage

// File: rtl/adcspi_pin_sync.sv
module adcspi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic cs_n,
    input  logic din,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_act,
    output logic din_s
);
    logic [STAGES-1:0] sck_p;
    logic [STAGES-1:0] csn_p;
    logic [STAGES-1:0] din_p;
    logic              sck_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p <= '0;
            csn_p <= '1;
            din_p <= '0;
            sck_d <= 1'b0;
        end else begin
            sck_p <= {sck_p[STAGES-2:0], sclk};
            csn_p <= {csn_p[STAGES-2:0], cs_n};
            din_p <= {din_p[STAGES-2:0], din};
            sck_d <= sck_p[STAGES-1];
        end
    end

    assign sck_rise = sck_p[STAGES-1] & ~sck_d;
    assign sck_fall = ~sck_p[STAGES-1] & sck_d;
    assign cs_act   = ~csn_p[STAGES-1];
    assign din_s    = din_p[STAGES-1];
endmodule

// File: rtl/adcspi_link.sv
module adcspi_link
    import adcspi_pkg::*;
#(
    parameter int ONES_LIMIT = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              cs_act,
    input  logic              din_s,
    input  logic              drdy_n,
    input  logic [WORD_W-1:0] rd_word,
    output reg_addr_e         addr,
    output logic              wr_stb,
    output logic [WORD_W-1:0] wr_word,
    output logic              rd_done,
    output logic              dout,
    output logic              dout_en
);
    localparam int ONES_W = $clog2(ONES_LIMIT + 1);

    phase_e            phase;
    cmd_t              cur;
    logic [7:0]        cmd_sh;
    logic [4:0]        bit_cnt;
    logic [WORD_W-1:0] rx_sh;
    logic [WORD_W-1:0] tx_sh;
    logic [ONES_W-1:0] ones;
    logic              load_pend;
    logic              shift_pend;

    logic [7:0]        cmd_nx;
    logic [WORD_W-1:0] rx_nx;
    logic [4:0]        last_bit;
    logic              flush;
    logic [WORD_W-1:0] tx_load;

    always_comb begin
        cmd_nx   = {cmd_sh[6:0], din_s};
        rx_nx    = {rx_sh[WORD_W-2:0], din_s};
        last_bit = {reg_bytes(cur.addr), 3'b000} - 5'd1;
        flush    = sck_rise && din_s && (ones == ONES_W'(ONES_LIMIT - 1));
        case (reg_bytes(cur.addr))
            2'd1:    tx_load = {rd_word[7:0], 16'h0000};
            2'd2:    tx_load = {rd_word[15:0], 8'h00};
            default: tx_load = rd_word;
        endcase
    end

    always_ff @(posedge clk) begin
        wr_stb  <= 1'b0;
        rd_done <= 1'b0;
        if (rst || !cs_act) begin
            phase      <= PH_CMD;
            cur        <= '0;
            cmd_sh     <= '0;
            bit_cnt    <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            ones       <= '0;
            load_pend  <= 1'b0;
            shift_pend <= 1'b0;
            wr_word    <= '0;
        end else begin
            if (sck_fall && shift_pend) begin
                tx_sh      <= tx_sh << 1;
                shift_pend <= 1'b0;
            end
            if (load_pend) begin
                load_pend <= 1'b0;
                tx_sh     <= tx_load;
            end
            if (sck_rise) begin
                ones <= din_s ? ones + 1'b1 : '0;
                if (flush) begin
                    phase   <= PH_CMD;
                    bit_cnt <= '0;
                    ones    <= '0;
                end else if (phase == PH_CMD) begin
                    cmd_sh <= cmd_nx;
                    if (bit_cnt == 5'd7) begin
                        bit_cnt <= '0;
                        if (!cmd_nx[7]) begin
                            cur       <= '{rd: cmd_nx[6], addr: reg_addr_e'(cmd_nx[5:3])};
                            phase     <= PH_DATA;
                            load_pend <= cmd_nx[6];
                        end
                    end else begin
                        bit_cnt <= bit_cnt + 5'd1;
                    end
                end else begin
                    rx_sh      <= rx_nx;
                    shift_pend <= 1'b1;
                    if (bit_cnt == last_bit) begin
                        bit_cnt <= '0;
                        phase   <= PH_CMD;
                        wr_stb  <= !cur.rd;
                        wr_word <= rx_nx;
                        rd_done <= cur.rd && (cur.addr == A_DATA);
                    end else begin
                        bit_cnt <= bit_cnt + 5'd1;
                    end
                end
            end
        end
    end

    assign addr    = cur.addr;
    assign dout_en = cs_act;
    assign dout    = (phase == PH_DATA && cur.rd) ? tx_sh[WORD_W-1] : drdy_n;
endmodule

// File: rtl/adcspi_regfile.sv
module adcspi_regfile
    import adcspi_pkg::*;
#(
    parameter int         NBANK    = 4,
    parameter logic [3:0] ID_UPPER = 4'h0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  reg_addr_e         addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_done,
    input  logic              smp_valid,
    input  logic [WORD_W-1:0] smp_word,
    input  logic [2:0]        smp_chan,
    output logic [WORD_W-1:0] rd_word,
    output logic [15:0]       mode_q,
    output logic [15:0]       cfg_q,
    output logic [WORD_W-1:0] cal_offset,
    output logic [WORD_W-1:0] cal_gain,
    output logic              drdy_n
);
    localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1;

    logic [WORD_W-1:0] offs  [NBANK];
    logic [WORD_W-1:0] gains [NBANK];
    logic [WORD_W-1:0] data_q;
    logic [2:0]        chd_q;
    logic [BANK_W-1:0] bank;
    logic              cal_we;

    assign bank   = cfg_q[BANK_W-1:0];
    assign cal_we = wr_stb && cal_writable(mode_q[15:13]);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                offs[b]  <= OFFS_RST;
                gains[b] <= GAIN_RST;
            end else if (cal_we && bank == BANK_W'(b)) begin
                if (addr == A_OFFS) offs[b]  <= wr_word;
                if (addr == A_GAIN) gains[b] <= wr_word;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RST;
            cfg_q  <= CONF_RST;
        end else if (wr_stb) begin
            if (addr == A_MODE) mode_q <= wr_word[15:0];
            if (addr == A_CONF) cfg_q  <= wr_word[15:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            chd_q  <= '0;
            drdy_n <= 1'b1;
        end else if (smp_valid) begin
            data_q <= smp_word;
            chd_q  <= smp_chan;
            drdy_n <= 1'b0;
        end else if (rd_done) begin
            drdy_n <= 1'b1;
        end
    end

    assign cal_offset = offs[bank];
    assign cal_gain   = gains[bank];

    always_comb begin
        case (addr)
            A_STAT:  rd_word = {16'h0000, drdy_n, 3'b000, 1'b1, chd_q};
            A_MODE:  rd_word = {8'h00, mode_q};
            A_CONF:  rd_word = {8'h00, cfg_q};
            A_DATA:  rd_word = data_q;
            A_IDEN:  rd_word = {16'h0000, ID_UPPER, 4'b1011};
            A_OFFS:  rd_word = cal_offset;
            A_GAIN:  rd_word = cal_gain;
            default: rd_word = '0;
        endcase
    end
endmodule

// File: rtl/adc_spi_regs.sv
module adc_spi_regs
    import adcspi_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         ONES_LIMIT  = 32,
    parameter int         NBANK       = 4,
    parameter logic [3:0] ID_UPPER    = 4'h0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              din,
    output logic              dout,
    output logic              dout_en,
    input  logic              smp_valid,
    input  logic [WORD_W-1:0] smp_word,
    input  logic [2:0]        smp_chan,
    output logic [15:0]       mode_q,
    output logic [15:0]       cfg_q,
    output logic [WORD_W-1:0] cal_offset,
    output logic [WORD_W-1:0] cal_gain
);
    logic              sck_rise, sck_fall, cs_act, din_s;
    logic              drdy_n, wr_stb, rd_done;
    reg_addr_e         link_addr;
    logic [WORD_W-1:0] wr_word, rd_word;

    adcspi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .din(din),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act), .din_s(din_s)
    );

    adcspi_link #(.ONES_LIMIT(ONES_LIMIT)) u_link (
        .clk(clk), .rst(rst), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .cs_act(cs_act), .din_s(din_s), .drdy_n(drdy_n), .rd_word(rd_word),
        .addr(link_addr), .wr_stb(wr_stb), .wr_word(wr_word), .rd_done(rd_done),
        .dout(dout), .dout_en(dout_en)
    );

    adcspi_regfile #(.NBANK(NBANK), .ID_UPPER(ID_UPPER)) u_regs (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .addr(link_addr), .wr_word(wr_word),
        .rd_done(rd_done), .smp_valid(smp_valid), .smp_word(smp_word), .smp_chan(smp_chan),
        .rd_word(rd_word), .mode_q(mode_q), .cfg_q(cfg_q), .cal_offset(cal_offset),
        .cal_gain(cal_gain), .drdy_n(drdy_n)
    );
endmodule

// File: rtl/adc_spi_regs_chk.sv
module adc_spi_regs_chk (
    input logic        clk,
    input logic        rst,
    input logic        cs_n,
    input logic        dout_en,
    input logic        smp_valid,
    input logic        drdy_n,
    input logic        rd_done,
    input logic        wr_stb,
    input logic [2:0]  wr_addr,
    input logic [15:0] mode_q,
    input logic [15:0] cfg_q,
    input logic [23:0] cal_offset,
    input logic [23:0] cal_gain
);
    logic [2:0] age;

    always_ff @(posedge clk) begin
        if (rst) age <= '0;
        else if (age != 3'd4) age <= age + 3'd1;
    end

    // R4: deselected for several cycles means the pin is released
    a_r4_release_pin: assert property (@(posedge clk) disable iff (rst)
        (age == 3'd4 && cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !dout_en);

    // R2: a core strobe always flags data ready on the next clock
    a_r2_strobe_flags: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> !drdy_n);

    // R3: the flag only returns high after a completed result read
    a_r3_set_by_read: assert property (@(posedge clk) disable iff (rst)
        (age != 3'd0 && drdy_n && !$past(drdy_n)) |-> $past(rd_done));

    // R10: calibration outputs move only in idle/sleep or on a bank switch
    a_r10_cal_guard: assert property (@(posedge clk) disable iff (rst)
        (age != 3'd0 && (cal_offset != $past(cal_offset) || cal_gain != $past(cal_gain)))
        |-> ($past(mode_q[15:14]) == 2'b01 || cfg_q[1:0] != $past(cfg_q[1:0])));

    // R8: the mode word changes only through a committed write to address 1
    a_r8_mode_by_write: assert property (@(posedge clk) disable iff (rst)
        (age != 3'd0 && mode_q != $past(mode_q)) |-> ($past(wr_stb) && $past(wr_addr) == 3'd1));
endmodule

bind adc_spi_regs adc_spi_regs_chk u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .dout_en(dout_en), .smp_valid(smp_valid),
    .drdy_n(drdy_n), .rd_done(rd_done), .wr_stb(wr_stb), .wr_addr(link_addr),
    .mode_q(mode_q), .cfg_q(cfg_q), .cal_offset(cal_offset), .cal_gain(cal_gain)
);

// File: tb/tb_adc_spi_regs.sv
module tb_adc_spi_regs;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        din = 1'b0;
    logic        smp_valid = 1'b0;
    logic [23:0] smp_word = '0;
    logic [2:0]  smp_chan = '0;
    logic        dout, dout_en;
    logic [15:0] mode_q, cfg_q;
    logic [23:0] cal_offset, cal_gain;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;
    bit cmp_on = 1'b0;

    // behavioural reference state
    logic [15:0] m_mode = 16'h000A;
    logic [15:0] m_cfg  = 16'h0710;
    logic [23:0] m_off  [4] = '{24'h800000, 24'h800000, 24'h800000, 24'h800000};
    logic [23:0] m_gain [4] = '{24'h555555, 24'h555555, 24'h555555, 24'h555555};
    logic [23:0] m_data = '0;
    logic [2:0]  m_chd  = '0;
    logic        m_rdy_n = 1'b1;

    always #2.5 clk = ~clk;

    adc_spi_regs dut (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .din(din),
        .dout(dout), .dout_en(dout_en), .smp_valid(smp_valid), .smp_word(smp_word),
        .smp_chan(smp_chan), .mode_q(mode_q), .cfg_q(cfg_q),
        .cal_offset(cal_offset), .cal_gain(cal_gain)
    );

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            chk("R8 mode", {8'h00, mode_q}, {8'h00, m_mode});
            chk("R8 config", {8'h00, cfg_q}, {8'h00, m_cfg});
            chk("R9 offset port", cal_offset, m_off[m_cfg[1:0]]);
            chk("R9 gain port", cal_gain, m_gain[m_cfg[1:0]]);
        end
    end

    function automatic int nbytes(input logic [2:0] a);
        if (a == 3'd1 || a == 3'd2) return 2;
        if (a == 3'd3 || a == 3'd6 || a == 3'd7) return 3;
        return 1;
    endfunction

    task automatic sbit(input logic b, output logic o);
        din = b;
        repeat (HALF) @(negedge clk);
        o = dout;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        logic o;
        for (int i = 7; i >= 0; i--) sbit(v[i], o);
    endtask

    task automatic xfer(input logic [7:0] cmd, input int nb, input logic [23:0] wd,
                        output logic [23:0] rd);
        logic o;
        rd = '0;
        send_byte(cmd);
        for (int i = nb * 8 - 1; i >= 0; i--) begin
            sbit(wd[i], o);
            rd = {rd[22:0], o};
        end
    endtask

    task automatic cs_down();
        cmp_on = 1'b0;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_up();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [23:0] v);
        cs_down();
        xfer({2'b01, a, 3'b000}, nbytes(a), 24'h0, v);
        cs_up();
        if (a == 3'd3) m_rdy_n = 1'b1;
        cmp_on = 1'b1;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [23:0] v);
        logic [23:0] dummy;
        cs_down();
        xfer({2'b00, a, 3'b000}, nbytes(a), v, dummy);
        cs_up();
        if (a == 3'd1) m_mode = v[15:0];
        if (a == 3'd2) m_cfg = v[15:0];
        if ((a == 3'd6 || a == 3'd7) && (m_mode[15:13] == 3'b010 || m_mode[15:13] == 3'b011)) begin
            if (a == 3'd6) m_off[m_cfg[1:0]] = v;
            else           m_gain[m_cfg[1:0]] = v;
        end
        cmp_on = 1'b1;
    endtask

    task automatic push_sample(input logic [23:0] w, input logic [2:0] c);
        @(negedge clk);
        smp_valid = 1'b1; smp_word = w; smp_chan = c;
        @(negedge clk);
        smp_valid = 1'b0;
        m_data = w; m_chd = c; m_rdy_n = 1'b0;
    endtask

    function automatic logic [23:0] exp_status();
        return {16'h0, m_rdy_n, 3'b000, 1'b1, m_chd};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [23:0] v;
        logic [23:0] junk;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1 reset values at the ports
        chk("R1 mode", {8'h0, mode_q}, 24'h00000A);
        chk("R1 config", {8'h0, cfg_q}, 24'h000710);
        chk("R1 offset", cal_offset, 24'h800000);
        chk("R1 gain", cal_gain, 24'h555555);
        chk("R4 released", {23'h0, dout_en}, 24'h0);
        cmp_on = 1'b1;

        rd_reg(3'd0, v); chk("R1 R7 status", v, 24'h000088);
        rd_reg(3'd3, v); chk("R1 data", v, 24'h000000);
        rd_reg(3'd4, v); chk("R6 id", v, 24'h00000B);
        rd_reg(3'd1, v); chk("R5 read mode", v, 24'h00000A);

        // R4 idle pin reflects flag
        cs_down();
        chk("R4 enabled", {23'h0, dout_en}, 24'h1);
        chk("R4 idle no data", {23'h0, dout}, 24'h1);
        push_sample(24'h123456, 3'd1);
        repeat (3) @(negedge clk);
        chk("R2 R4 pin low", {23'h0, dout}, 24'h0);
        cs_up();
        cmp_on = 1'b1;

        rd_reg(3'd0, v); chk("R2 R7 status", v, exp_status());
        rd_reg(3'd3, v); chk("R2 data", v, 24'h123456);
        rd_reg(3'd0, v); chk("R3 status after read", v, exp_status());
        cs_down();
        chk("R3 pin high", {23'h0, dout}, 24'h1);
        cs_up();
        cmp_on = 1'b1;

        // R8 writes to read-only addresses ignored
        push_sample(24'hA5A5A5, 3'd3);
        wr_reg(3'd3, 24'h0F0F0F);
        wr_reg(3'd0, 24'h0000FF);
        wr_reg(3'd4, 24'h000000);
        wr_reg(3'd5, 24'h0000FF);
        rd_reg(3'd0, v); chk("R8 status untouched", v, exp_status());
        rd_reg(3'd3, v); chk("R8 data untouched", v, 24'hA5A5A5);
        rd_reg(3'd4, v); chk("R8 id untouched", v, 24'h00000B);

        // R10 calibration protected while converting
        wr_reg(3'd6, 24'h111111);
        rd_reg(3'd6, v); chk("R10 offset locked", v, 24'h800000);
        wr_reg(3'd1, 24'h00400A);
        rd_reg(3'd1, v); chk("R8 mode written", v, 24'h00400A);
        wr_reg(3'd6, 24'h111111);
        rd_reg(3'd6, v); chk("R10 offset idle write", v, 24'h111111);
        wr_reg(3'd2, 24'h000711);
        rd_reg(3'd6, v); chk("R9 bank1 offset", v, 24'h800000);
        wr_reg(3'd1, 24'h00600A);
        wr_reg(3'd7, 24'h222222);
        rd_reg(3'd7, v); chk("R10 gain sleep write", v, 24'h222222);
        wr_reg(3'd2, 24'h000710);
        rd_reg(3'd7, v); chk("R9 bank0 gain", v, 24'h555555);
        rd_reg(3'd6, v); chk("R9 bank0 offset", v, 24'h111111);
        wr_reg(3'd1, 24'h00200A);
        wr_reg(3'd7, 24'h333333);
        rd_reg(3'd7, v); chk("R10 gain single locked", v, 24'h555555);

        // R5 a command with bit 7 set is dropped
        cs_down();
        send_byte(8'h88);
        xfer(8'h48, 2, 24'h0, v);
        chk("R5 dropped command", v, {8'h0, m_mode});
        cs_up();
        cmp_on = 1'b1;

        // R11 framing slip recovered by 32 ones
        cs_down();
        for (int i = 0; i < 3; i++) sbit(1'b0, junk[0]);
        for (int i = 0; i < 32; i++) sbit(1'b1, junk[0]);
        xfer(8'h48, 2, 24'h0, v);
        chk("R11 resync", v, {8'h0, m_mode});
        cs_up();
        cmp_on = 1'b1;
        rd_reg(3'd3, v); chk("R11 data kept", v, 24'hA5A5A5);

        // R12 abandoned write
        cs_down();
        send_byte(8'h08);
        send_byte(8'hFF);
        cs_up();
        cmp_on = 1'b1;
        rd_reg(3'd1, v); chk("R12 not committed", v, {8'h0, m_mode});
        repeat (4) @(negedge clk);
        chk("R4 released end", {23'h0, dout_en}, 24'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule